// File: doc/BRIEF.md
# Dual-Channel Bus Breakpoint Comparator

This block watches the bus cycles a processor issues and pulses a break request when a cycle meets a programmed condition. It has two comparison channels. Each channel holds a reference address with a don't-care mask and a reference data value with its own mask. It also holds qualifiers that pick which bus, which access kind (instruction fetch or data), which direction and which access size may match. Channel A also has an execution counter, so a break can be held back until the Nth matching cycle.

The two channels run either independently, each able to request a break, or in a sequential mode. In sequential mode a channel A event only arms the unit, and channel B requests the break on its next match after arming. Configuration goes through a small write port. The monitor side takes one bus cycle per clock while `mon_valid` is high. For fetch conditions the request is meant to reach the core before the fetched instruction executes. Steering the core into an exception is left to the surrounding logic.

Top module: `bus_break_unit`

## Requirements
- R1: Register selects on `cfg_sel`: 0..4 are channel A address, address mask, data, data mask and condition; 5..9 are the same five for channel B; 10 is the mode word (bit 0 sequential, bit 1 count enable); 11 loads the execution count; 12 writes the flags. After reset every condition is zero, so no cycle can raise a request, and `brk_req`, `brk_flag_a` and `brk_flag_b` are low.
- R2: Address bits whose mask bit is 1 are ignored. Every other address bit must equal the reference.
- R3: Condition bits [1:0] allow bus 0 / bus 1 (`mon_bus` low / high). Bits [3:2] allow fetch / data cycles. Bits [5:4] allow read / write. A cycle whose bus, kind or direction is not allowed never matches.
- R4: Condition bits [7:6] pick the size: 0 any, 1 byte, 2 word, 3 longword. `mon_size` codes byte as 0, word as 1 and longword as 2.
- R5: When condition bit 8 is set, a data cycle also needs its unmasked data bits to equal the data reference. Fetch cycles ignore the data comparison.
- R6: In independent mode either channel's hit pulses `brk_req`. `brk_src` is 0 for channel A and 1 for channel B, and A wins when both hit in the same cycle.
- R7: In sequential mode a channel A event arms the unit without requesting a break. The next channel B match requests a break with `brk_src` = 1 and disarms the unit.
- R8: In sequential mode, when channel A's condition can never match the cycles on the bus, channel B never requests a break.
- R9: With counting enabled and count N loaded, the first N-1 channel A matches step the count down silently and the Nth match is the A event. Once the count is exhausted, channel A gives no event until the count is reloaded.
- R10: `brk_req` rises one clock after the qualifying bus cycle and lasts one clock per event.
- R11: A channel's flag is set by its event and stays set. Writing select 12 with a 0 in bit 0 (A) or bit 1 (B) clears that flag, and a 1 leaves it as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 4 | Register select |
| cfg_wdata | input | 32 | Register write data |
| mon_valid | input | 1 | A bus cycle is present this clock |
| mon_addr | input | AW | Bus cycle address |
| mon_data | input | DW | Bus cycle data |
| mon_bus | input | 1 | Which bus carries the cycle |
| mon_fetch | input | 1 | 1 for instruction fetch, 0 for data access |
| mon_write | input | 1 | 1 for write, 0 for read |
| mon_size | input | 2 | Access size code |
| brk_req | output | 1 | One-clock break request pulse |
| brk_src | output | 1 | Channel of the last request (0 A, 1 B) |
| brk_flag_a | output | 1 | Sticky channel A event flag |
| brk_flag_b | output | 1 | Sticky channel B event flag |

## Verification
The bench goes after the masked address bits. A design that compared them would miss a hit inside the masked window, and one that dropped unmasked bits would fire outside it. It checks that a fetch still matches when its data differs from the reference, since a design that applied the data compare to fetches would lose those breaks. It steps the execution count through N = 5 and a reload. An off-by-one counter fires on the fourth or sixth match, and one that wraps fires again after the count is exhausted. It runs the sequential order B, A, B, B and a channel A condition that cannot match. A design that let B fire unarmed, failed to disarm, or let A request on its own in that mode would show an extra or a missing pulse.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

   // Match condition word, one per channel (bit 8 down to bit 0).
   typedef struct packed {
      logic       dcmp_en;   // data comparison on data cycles
      logic [1:0] size_q;    // 0 any, 1 byte, 2 word, 3 longword
      logic [1:0] dir_q;     // [0] read allowed, [1] write allowed
      logic [1:0] kind_q;    // [0] fetch allowed, [1] data allowed
      logic [1:0] bus_q;     // [0] bus 0 allowed, [1] bus 1 allowed
   } cond_t;

   localparam int COND_W = $bits(cond_t);

   localparam int NCH        = 2;
   localparam int SEL_STRIDE = 5;
   localparam int SEL_ADDR   = 0;
   localparam int SEL_AMASK  = 1;
   localparam int SEL_DATA   = 2;
   localparam int SEL_DMASK  = 3;
   localparam int SEL_COND   = 4;
   localparam int SEL_MODE   = 10;
   localparam int SEL_COUNT  = 11;
   localparam int SEL_FLAGS  = 12;

endpackage

// File: rtl/bkpt_chan_match.sv
module bkpt_chan_match
   import bkpt_pkg::*;
#(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter bit DATA_CMP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  cond_t         cond,
   input  logic [AW-1:0] ref_addr,
   input  logic [AW-1:0] addr_mask,
   input  logic [DW-1:0] ref_data,
   input  logic [DW-1:0] data_mask,
   input  logic          mon_valid,
   input  logic [AW-1:0] mon_addr,
   input  logic [DW-1:0] mon_data,
   input  logic          mon_bus,
   input  logic          mon_fetch,
   input  logic          mon_write,
   input  logic [1:0]    mon_size,
   output logic          hit
);

   logic       bus_ok, kind_ok, dir_ok, size_ok, addr_ok, data_ok;
   logic [2:0] size_code;

   always_comb begin
      bus_ok    = mon_bus   ? cond.bus_q[1]  : cond.bus_q[0];
      kind_ok   = mon_fetch ? cond.kind_q[0] : cond.kind_q[1];
      dir_ok    = mon_write ? cond.dir_q[1]  : cond.dir_q[0];
      size_code = {1'b0, mon_size} + 3'd1;
      size_ok   = (cond.size_q == 2'd0) || ({1'b0, cond.size_q} == size_code);
      addr_ok   = (((mon_addr ^ ref_addr) & ~addr_mask) == '0);
   end

   generate
      if (DATA_CMP) begin : g_dcmp
         always_comb
            data_ok = !cond.dcmp_en || mon_fetch ||
                      (((mon_data ^ ref_data) & ~data_mask) == '0);
      end else begin : g_no_dcmp
         logic unused_dcmp;
         assign unused_dcmp = ^{mon_data, ref_data, data_mask, cond.dcmp_en};
         assign data_ok = 1'b1;
      end
   endgenerate

   assign hit = mon_valid && bus_ok && kind_ok && dir_ok && size_ok && addr_ok && data_ok;

   // R1: an unconfigured bus qualifier admits nothing
   a_r1_no_bus_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      (cond.bus_q == 2'b00) |-> !hit);
   // R3: a write cycle only hits when writes are allowed
   a_r3_write_allowed: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mon_write) |-> cond.dir_q[1]);
   // R2: a hit never differs from the reference on an unmasked bit
   a_r2_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (((mon_addr ^ ref_addr) & ~addr_mask) == '0));

endmodule

// File: rtl/bkpt_exec_count.sv
module bkpt_exec_count #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          enable,
   input  logic          match_in,
   output logic          fire
);

   localparam logic [CW-1:0] ONE = CW'(1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (enable && match_in && (cnt_q != '0))
         cnt_q <= cnt_q - ONE;
   end

   assign fire = match_in && (!enable || (cnt_q == ONE));

   // R9: an exhausted count stays exhausted until reloaded
   a_r9_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && (cnt_q == '0)) |=> (cnt_q == '0));
   // R9: each counted match below the target steps the count by one
   a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && enable && match_in && (cnt_q > ONE)) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/bkpt_break_ctrl.sv
module bkpt_break_ctrl (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       seq_mode,
   input  logic       a_event,
   input  logic       b_match,
   input  logic       flag_wr,
   input  logic [1:0] flag_wdata,
   output logic       brk_req,
   output logic       brk_src,
   output logic       flag_a,
   output logic       flag_b
);

   logic armed_q;
   logic a_req, b_event;

   always_comb begin
      a_req   = !seq_mode && a_event;
      b_event = seq_mode ? (armed_q && b_match) : b_match;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         brk_req <= 1'b0;
         brk_src <= 1'b0;
         flag_a  <= 1'b0;
         flag_b  <= 1'b0;
      end else begin
         armed_q <= seq_mode && (a_event || (armed_q && !b_match));
         brk_req <= a_req || b_event;
         if (a_req || b_event)
            brk_src <= !a_req;
         flag_a <= a_event || (flag_a && !(flag_wr && !flag_wdata[0]));
         flag_b <= b_event || (flag_b && !(flag_wr && !flag_wdata[1]));
      end
   end

   // R7: arming only follows a channel A event
   a_r7_arm_from_a: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(a_event));
   // R7: a channel B request in sequential mode needs a prior arm
   a_r7_b_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_req && brk_src && $past(seq_mode)) |-> $past(armed_q));
   // R6: simultaneous hits in independent mode report channel A
   a_r6_a_first: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_mode && a_event && b_match) |=> (brk_req && !brk_src));
   // R11: a flag holds while no flag write occurs
   a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_a && !flag_wr) |=> flag_a);

endmodule

// File: rtl/bus_break_unit.sv
module bus_break_unit
   import bkpt_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 16,
   parameter bit HAS_COUNT = 1'b1,
   parameter bit HAS_DCMP  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [3:0]    cfg_sel,
   input  logic [31:0]   cfg_wdata,
   input  logic          mon_valid,
   input  logic [AW-1:0] mon_addr,
   input  logic [DW-1:0] mon_data,
   input  logic          mon_bus,
   input  logic          mon_fetch,
   input  logic          mon_write,
   input  logic [1:0]    mon_size,
   output logic          brk_req,
   output logic          brk_src,
   output logic          brk_flag_a,
   output logic          brk_flag_b
);

   generate
      if (AW < 1 || AW > 32) begin : g_bad_aw
         $error("bus_break_unit: AW must be 1..32");
      end
      if (DW < 1 || DW > 32) begin : g_bad_dw
         $error("bus_break_unit: DW must be 1..32");
      end
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("bus_break_unit: CW must be 2..32");
      end
   endgenerate

   logic [AW-1:0] ref_addr_q  [NCH];
   logic [AW-1:0] addr_mask_q [NCH];
   logic [DW-1:0] ref_data_q  [NCH];
   logic [DW-1:0] data_mask_q [NCH];
   cond_t         cond_q      [NCH];
   logic          seq_mode_q, cnt_en_q;
   logic [NCH-1:0] ch_hit;
   logic          a_event;
   logic          cnt_load, flag_wr;
   logic          unused_wdata;

   assign unused_wdata = ^cfg_wdata;
   assign cnt_load     = cfg_we && (cfg_sel == 4'(SEL_COUNT));
   assign flag_wr      = cfg_we && (cfg_sel == 4'(SEL_FLAGS));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_mode_q <= 1'b0;
         cnt_en_q   <= 1'b0;
         for (int ch = 0; ch < NCH; ch++) begin
            ref_addr_q[ch]  <= '0;
            addr_mask_q[ch] <= '0;
            ref_data_q[ch]  <= '0;
            data_mask_q[ch] <= '0;
            cond_q[ch]      <= '0;
         end
      end else if (cfg_we) begin
         if (cfg_sel == 4'(SEL_MODE)) begin
            seq_mode_q <= cfg_wdata[0];
            cnt_en_q   <= cfg_wdata[1];
         end
         for (int ch = 0; ch < NCH; ch++) begin
            if (cfg_sel == 4'(ch * SEL_STRIDE + SEL_ADDR))
               ref_addr_q[ch] <= cfg_wdata[AW-1:0];
            if (cfg_sel == 4'(ch * SEL_STRIDE + SEL_AMASK))
               addr_mask_q[ch] <= cfg_wdata[AW-1:0];
            if (cfg_sel == 4'(ch * SEL_STRIDE + SEL_DATA))
               ref_data_q[ch] <= cfg_wdata[DW-1:0];
            if (cfg_sel == 4'(ch * SEL_STRIDE + SEL_DMASK))
               data_mask_q[ch] <= cfg_wdata[DW-1:0];
            if (cfg_sel == 4'(ch * SEL_STRIDE + SEL_COND))
               cond_q[ch] <= cond_t'(cfg_wdata[COND_W-1:0]);
         end
      end
   end

   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
         bkpt_chan_match #(
            .AW       (AW),
            .DW       (DW),
            .DATA_CMP (HAS_DCMP)
         ) u_match (
            .clk       (clk),
            .rst_n     (rst_n),
            .cond      (cond_q[ch]),
            .ref_addr  (ref_addr_q[ch]),
            .addr_mask (addr_mask_q[ch]),
            .ref_data  (ref_data_q[ch]),
            .data_mask (data_mask_q[ch]),
            .mon_valid (mon_valid),
            .mon_addr  (mon_addr),
            .mon_data  (mon_data),
            .mon_bus   (mon_bus),
            .mon_fetch (mon_fetch),
            .mon_write (mon_write),
            .mon_size  (mon_size),
            .hit       (ch_hit[ch])
         );
      end

      if (HAS_COUNT) begin : g_count
         bkpt_exec_count #(.CW(CW)) u_count (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cnt_load),
            .load_val (cfg_wdata[CW-1:0]),
            .enable   (cnt_en_q),
            .match_in (ch_hit[0]),
            .fire     (a_event)
         );
      end else begin : g_no_count
         logic unused_count;
         assign unused_count = cnt_load ^ cnt_en_q;
         assign a_event = ch_hit[0];
      end
   endgenerate

   bkpt_break_ctrl u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .seq_mode   (seq_mode_q),
      .a_event    (a_event),
      .b_match    (ch_hit[1]),
      .flag_wr    (flag_wr),
      .flag_wdata (cfg_wdata[1:0]),
      .brk_req    (brk_req),
      .brk_src    (brk_src),
      .flag_a     (brk_flag_a),
      .flag_b     (brk_flag_b)
   );

   // R10: every request traces back to a bus cycle one clock earlier
   a_r10_req_needs_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      brk_req |-> $past(mon_valid));

endmodule

// File: tb/sim_bus_break_unit.sv
module sim_bus_break_unit;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        mon_valid = 1'b0;
   logic [31:0] mon_addr = '0;
   logic [31:0] mon_data = '0;
   logic        mon_bus = 1'b0;
   logic        mon_fetch = 1'b0;
   logic        mon_write = 1'b0;
   logic [1:0]  mon_size = '0;
   logic        brk_req, brk_src, brk_flag_a, brk_flag_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_break_unit u0 (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .mon_valid(mon_valid), .mon_addr(mon_addr), .mon_data(mon_data), .mon_bus(mon_bus),
      .mon_fetch(mon_fetch), .mon_write(mon_write), .mon_size(mon_size),
      .brk_req(brk_req), .brk_src(brk_src), .brk_flag_a(brk_flag_a), .brk_flag_b(brk_flag_b)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // Drive one bus cycle, then sample the registered outputs it produced.
   task automatic cyc(input logic [31:0] a, input logic [31:0] d, input logic bus,
                      input logic fetch, input logic w, input logic [1:0] sz,
                      output logic req, output logic src);
      @(negedge clk);
      mon_valid = 1'b1; mon_addr = a; mon_data = d;
      mon_bus = bus; mon_fetch = fetch; mon_write = w; mon_size = sz;
      @(negedge clk);
      mon_valid = 1'b0;
      req = brk_req; src = brk_src;
   endtask

   function automatic logic model_hit(input logic [31:0] ra, am, rd, dm, input logic [8:0] c,
                                      input logic [31:0] a, d, input logic bus, fetch, w,
                                      input logic [1:0] sz);
      logic ok;
      ok = bus ? c[1] : c[0];
      ok = ok && (fetch ? c[2] : c[3]);
      ok = ok && (w ? c[5] : c[4]);
      if (c[7:6] != 2'd0) ok = ok && (sz != 2'd3) && (c[7:6] == sz + 2'd1);
      ok = ok && (((a ^ ra) & ~am) == 32'd0);
      if (c[8] && !fetch) ok = ok && (((d ^ rd) & ~dm) == 32'd0);
      return ok;
   endfunction

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic r, s;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 req after reset", 32'(brk_req), 0);
      check("R1 flag_a after reset", 32'(brk_flag_a), 0);
      check("R1 flag_b after reset", 32'(brk_flag_b), 0);
      cyc(32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R1 unconfigured cycle", 32'(r), 0);

      // R2 address mask
      wr(0, 32'h8404); wr(1, 32'hFFF); wr(4, 32'h017);
      cyc(32'h8ABC, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R2 masked bits ignored", 32'({r, s}), 32'b10);
      cyc(32'h9404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R2 unmasked bit differs", 32'(r), 0);

      // R3 cycle qualifiers
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b1, 2'd2, r, s);
      check("R3 write on read-only", 32'(r), 0);
      cyc(32'h8404, 0, 1'b0, 1'b0, 1'b0, 2'd2, r, s);
      check("R3 data on fetch-only", 32'(r), 0);
      wr(4, 32'h015);
      cyc(32'h8404, 0, 1'b1, 1'b1, 1'b0, 2'd2, r, s);
      check("R3 bus 1 excluded", 32'(r), 0);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R3 bus 0 allowed", 32'(r), 1);

      // R4 size
      wr(4, 32'h0D7);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd1, r, s);
      check("R4 word on long-only", 32'(r), 0);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd0, r, s);
      check("R4 byte on long-only", 32'(r), 0);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R4 long on long-only", 32'(r), 1);

      // R5 data compare
      wr(2, 32'h55); wr(3, 32'h0F); wr(4, 32'h11F);
      cyc(32'h8404, 32'hA5, 1'b0, 1'b0, 1'b0, 2'd0, r, s);
      check("R5 data mismatch", 32'(r), 0);
      cyc(32'h8404, 32'h5A, 1'b0, 1'b0, 1'b0, 2'd0, r, s);
      check("R5 data masked match", 32'(r), 1);
      cyc(32'h8404, 32'hFF, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R5 fetch ignores data", 32'(r), 1);

      // R6 independent mode and priority
      wr(4, 32'h017); wr(5, 32'h8404); wr(6, 32'h0); wr(9, 32'h017);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R6 both hit reports A", 32'({r, s}), 32'b10);
      check("R6 flag_b set too", 32'(brk_flag_b), 1);
      cyc(32'h8400, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R6 A alone", 32'({r, s}), 32'b10);
      wr(5, 32'h1000);
      cyc(32'h1000, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R6 B alone", 32'({r, s}), 32'b11);

      // R10 pulse width
      @(negedge clk);
      check("R10 pulse ends", 32'(brk_req), 0);

      // R11 flags
      wr(12, 32'h2);
      check("R11 A cleared by 0", 32'(brk_flag_a), 0);
      check("R11 B kept by 1", 32'(brk_flag_b), 1);
      wr(12, 32'h0);
      check("R11 B cleared", 32'(brk_flag_b), 0);

      // R9 execution count
      wr(10, 32'h2); wr(11, 32'd5);
      for (int i = 1; i <= 6; i++) begin
         cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
         check($sformatf("R9 count match %0d", i), 32'(r), (i == 5) ? 1 : 0);
      end
      wr(11, 32'd2);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R9 reload first", 32'(r), 0);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R9 reload second", 32'({r, s}), 32'b10);

      // R7 sequential mode
      wr(10, 32'h1); wr(1, 32'h0);
      cyc(32'h1000, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R7 B before arm", 32'(r), 0);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R7 A only arms", 32'(r), 0);
      cyc(32'h1000, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R7 B after arm", 32'({r, s}), 32'b11);
      cyc(32'h1000, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R7 disarmed after B", 32'(r), 0);

      // R8 impossible A condition
      wr(4, 32'h0AB);
      cyc(32'h8404, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      cyc(32'h1000, 0, 1'b0, 1'b1, 1'b0, 2'd2, r, s);
      check("R8 B never fires", 32'(r), 0);

      // Random independent-mode traffic against the model (R2..R6)
      wr(10, 32'h0);
      for (int k = 0; k < 6; k++) begin
         logic [31:0] ra [2];
         logic [31:0] am [2];
         logic [31:0] rd [2];
         logic [31:0] dm [2];
         logic [8:0]  cc [2];
         for (int ch = 0; ch < 2; ch++) begin
            ra[ch] = $urandom & 32'hFFFF_FF00;
            if (ch == 1 && k[0]) ra[1] = ra[0];
            am[ch] = $urandom & 32'hF0;
            rd[ch] = $urandom & 32'hFF;
            dm[ch] = $urandom & 32'hF;
            cc[ch] = 9'($urandom) | 9'h0FF & 9'($urandom | 32'h15);
            wr(ch * 5 + 0, ra[ch]); wr(ch * 5 + 1, am[ch]);
            wr(ch * 5 + 2, rd[ch]); wr(ch * 5 + 3, dm[ch]);
            wr(ch * 5 + 4, 32'(cc[ch]));
         end
         for (int n = 0; n < 40; n++) begin
            logic [31:0] a, d;
            logic bus, fe, w, ha, hb;
            logic [1:0] sz;
            a   = ra[$urandom % 2] ^ ($urandom & 32'h1F0);
            d   = rd[$urandom % 2] ^ ($urandom & 32'h1F);
            bus = 1'($urandom); fe = 1'($urandom); w = 1'($urandom); sz = 2'($urandom);
            ha = model_hit(ra[0], am[0], rd[0], dm[0], cc[0], a, d, bus, fe, w, sz);
            hb = model_hit(ra[1], am[1], rd[1], dm[1], cc[1], a, d, bus, fe, w, sz);
            cyc(a, d, bus, fe, w, sz, r, s);
            check("R6 random req", 32'(r), 32'(ha | hb));
            if (ha | hb) check("R6 random src", 32'(s), 32'(!ha));
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule